// File: doc/BRIEF.md
# Programmable-Width Decrementer Timer

This block holds a signed down-counter whose width is set by a parameter. The counter steps down by one on every clock cycle in which the timebase tick input is high. Software loads it through a single write port and reads it back on a 64-bit read bus, zero-extended. The counter does not stop at zero. When it crosses from zero into the negative range, the block raises an interrupt request. A write of a negative value can also raise the request.

A mode input selects one of two ways of treating the sign bit. In level mode the request follows software writes. Writing a negative value sets it, and writing a non-negative value clears it. The acknowledge input has no effect in this mode. In edge mode, a write sets the request only when it makes the counter go from non-negative to negative. Once set, the request stays high until it is acknowledged. A counter that wraps from its most negative value to its most positive value keeps counting and does not change the request.

The block has an asynchronous active-low reset. Reset is released synchronously to the clock. Every output changes on the same clock edge that samples the inputs that cause the change.

Top module: `dec_timer`

## Requirements
- R1: After reset the counter reads as all ones in its low DEC_W bits, with zeros above, and `irq` is low.
- R2: A write keeps only `wr_data[DEC_W-1:0]` and drops the upper bits. `rd_data` shows the stored value zero-extended to 64 bits from the next edge on.
- R3: With `tick_en` high and no write, the counter decrements by one per cycle. It wraps from the most negative value (1 followed by zeros) to the most positive value. With neither a tick nor a write, the counter holds its value.
- R4: When a write and a tick fall in the same cycle, the written value is stored and the decrement is lost.
- R5: A tick that takes the counter from 0 to all ones sets `irq` in either mode. A tick from 1 to 0 does not set it.
- R6: A write of a small positive value such as 1 or 2 does not set `irq` at once. The request is raised only when the counter later ticks from 0 to all ones.
- R7: In level mode (`irq_mode`=0), a write whose bit DEC_W-1 is 1 sets `irq`, whatever the previous value was.
- R8: In level mode, `irq` is cleared only by a write whose bit DEC_W-1 is 0. `irq_ack` and a wrap into the positive range leave it set.
- R9: In edge mode (`irq_mode`=1), a write sets `irq` only when the written value is negative and the previous counter value was non-negative.
- R10: In edge mode, `irq` stays set until `irq_ack` is sampled high, and then it clears. A non-negative write does not clear it. If a set event and an acknowledge fall in the same cycle, the request stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timebase tick; decrement enable for this cycle |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 64 | Write value; only the low DEC_W bits are kept |
| irq_mode | input | 1 | 0 = level semantics, 1 = edge semantics |
| irq_ack | input | 1 | Acknowledge, used in edge mode only |
| rd_data | output | 64 | Counter value, zero-extended |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the cases below and describes how a faulty design would fail each one.

- **Underflow boundary.** A design that raised the request early, on the 1-to-0 step or on a write of 1 or 2, would show `irq` high while the read value is still non-negative.
- **Wrap point.** The bench runs the counter through the wrap from the most negative value to the most positive value. A level-mode design that followed the live sign bit would drop the request there.
- **Edge-mode writes.** The bench writes negative values over both negative and non-negative counters. A design that ignored the previous value would raise a spurious request.
- **Same-cycle collisions.** The bench applies a write together with a tick, and a set event together with an acknowledge. A design with the priorities reversed would show a decremented value or a lost request.

// File: rtl/dec_pkg.sv
`timescale 1ns/1ps
package dec_pkg;
  typedef enum logic {
    IRQ_LEVEL = 1'b0,
    IRQ_EDGE  = 1'b1
  } irq_mode_e;

  localparam int unsigned RD_W = 64;
endpackage

// File: rtl/dec_rst_sync.sv
`timescale 1ns/1ps
module dec_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/dec_count.sv
`timescale 1ns/1ps
module dec_count #(
  parameter int unsigned DEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic [DEC_W-1:0] wr_val,
  output logic [DEC_W-1:0] cnt_q,
  output logic             ev_uflow,
  output logic             ev_wr_neg,
  output logic             ev_wr_pos,
  output logic             prev_nonneg
);
  localparam int unsigned SIGN = DEC_W - 1;

  logic [DEC_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = wr_en | tick_en;
    if (wr_en) cnt_d = wr_val;
    else       cnt_d = cnt_q - {{(DEC_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '1;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ev_uflow    = tick_en & ~wr_en & (cnt_q == '0);
  assign ev_wr_neg   = wr_en & wr_val[SIGN];
  assign ev_wr_pos   = wr_en & ~wr_val[SIGN];
  assign prev_nonneg = ~cnt_q[SIGN];

  // R2 R4
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cnt_q == $past(wr_val));

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_en) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_en) |=> $stable(cnt_q));
endmodule

// File: rtl/dec_irq.sv
`timescale 1ns/1ps
module dec_irq
  import dec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic ack,
  input  logic ev_uflow,
  input  logic ev_wr_neg,
  input  logic ev_wr_pos,
  input  logic prev_nonneg,
  output logic irq_q
);
  irq_mode_e mode_e;
  logic      set_ev;
  logic      clr_ev;
  logic      irq_d;

  always_comb begin
    mode_e = irq_mode_e'(mode);
    if (mode_e == IRQ_LEVEL) begin
      set_ev = ev_uflow | ev_wr_neg;
      clr_ev = ev_wr_pos;
    end else begin
      set_ev = ev_uflow | (ev_wr_neg & prev_nonneg);
      clr_ev = ack;
    end
    if (set_ev)      irq_d = 1'b1;
    else if (clr_ev) irq_d = 1'b0;
    else             irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  // R5
  uflow_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_uflow |=> irq_q);

  // R8
  level_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 1'b0 && ev_wr_pos) |=> !irq_q);

  // R8
  level_ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 1'b0 && irq_q && !ev_wr_pos) |=> irq_q);

  // R10
  edge_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 1'b1 && ack && !ev_uflow && !ev_wr_neg) |=> !irq_q);

  // R9
  edge_no_reraise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 1'b1 && !irq_q && !prev_nonneg && !ev_uflow) |=> !irq_q);
endmodule

// File: rtl/dec_timer.sv
`timescale 1ns/1ps
module dec_timer
  import dec_pkg::*;
#(
  parameter int unsigned DEC_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        wr_en,
  input  logic [63:0] wr_data,
  input  logic        irq_mode,
  input  logic        irq_ack,
  output logic [63:0] rd_data,
  output logic        irq
);
  localparam int unsigned PAD_W = RD_W - DEC_W;

  logic             rst_n_s;
  logic [DEC_W-1:0] cnt_q;
  logic             ev_uflow;
  logic             ev_wr_neg;
  logic             ev_wr_pos;
  logic             prev_nonneg;

  dec_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  dec_count #(.DEC_W(DEC_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .tick_en     (tick_en),
    .wr_en       (wr_en),
    .wr_val      (wr_data[DEC_W-1:0]),
    .cnt_q       (cnt_q),
    .ev_uflow    (ev_uflow),
    .ev_wr_neg   (ev_wr_neg),
    .ev_wr_pos   (ev_wr_pos),
    .prev_nonneg (prev_nonneg)
  );

  dec_irq u_irq (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .mode        (irq_mode),
    .ack         (irq_ack),
    .ev_uflow    (ev_uflow),
    .ev_wr_neg   (ev_wr_neg),
    .ev_wr_pos   (ev_wr_pos),
    .prev_nonneg (prev_nonneg),
    .irq_q       (irq)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^wr_data[RD_W-1:DEC_W];
      assign rd_data   = {{PAD_W{1'b0}}, cnt_q};
    end else begin : g_full
      assign rd_data = cnt_q;
    end
  endgenerate

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_n_s |=> !irq);

  // R2
  rd_pad_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_data >> DEC_W) == 64'd0);
endmodule

// File: tb/sim_dec_timer.sv
`timescale 1ns/1ps
module sim_dec_timer;
  localparam int unsigned W = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en, wr_en, irq_mode, irq_ack;
  logic [63:0] wr_data;
  logic [63:0] rd_data;
  logic        irq;

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;
  int unsigned cyc    = 0;
  bit          done   = 1'b0;

  logic [W-1:0] m_cnt;
  logic         m_irq;

  always #2 clk = ~clk;

  dec_timer #(.DEC_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_data(wr_data), .irq_mode(irq_mode), .irq_ack(irq_ack),
    .rd_data(rd_data), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: act=%0d cycles exp=<100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [63:0] zx(input logic [W-1:0] v);
    return {{(64-W){1'b0}}, v};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // model the requirements for one cycle
  task automatic model_step(input bit wr, input logic [63:0] d, input bit tk,
                            input bit md, input bit ak);
    logic [W-1:0] old;
    bit uf, wneg, setv, clrv;
    old  = m_cnt;
    uf   = tk && !wr && (old == '0);
    wneg = wr && d[W-1];
    if (wr)      m_cnt = d[W-1:0];
    else if (tk) m_cnt = old - 1'b1;
    if (!md) begin
      setv = uf || wneg;
      clrv = wr && !d[W-1];
    end else begin
      setv = uf || (wneg && !old[W-1]);
      clrv = ak;
    end
    if (setv)      m_irq = 1'b1;
    else if (clrv) m_irq = 1'b0;
  endtask

  task automatic step(input string tag, input bit wr, input logic [63:0] d,
                      input bit tk, input bit md, input bit ak);
    @(negedge clk);
    wr_en = wr; wr_data = d; tick_en = tk; irq_mode = md; irq_ack = ak;
    model_step(wr, d, tk, md, ak);
    @(posedge clk);
    #1;
    chk({tag, " rd_data"}, rd_data, zx(m_cnt));
    chk({tag, " irq"}, {63'd0, irq}, {63'd0, m_irq});
  endtask

  localparam logic [63:0] MINV = 64'h1 << (W-1);

  initial begin
    logic [63:0] d;
    bit wr, tk, ak, md;
    int unsigned r;
    void'($urandom(32'd1234));
    rst_n = 1'b0; tick_en = 0; wr_en = 0; wr_data = '0; irq_mode = 0; irq_ack = 0;
    m_cnt = '1; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 reset rd_data", rd_data, 64'h0000_0000_FFFF_FFFF);
    chk("R1 reset irq", {63'd0, irq}, 64'd0);

    // R2 truncation
    step("R2 truncate", 1, 64'hDEAD_BEEF_1234_5678, 0, 0, 0);
    chk("R2 literal", rd_data, 64'h0000_0000_1234_5678);
    // R4 write wins over tick
    step("R4 write+tick", 1, 64'd2, 1, 0, 0);
    chk("R4 literal", rd_data, 64'd2);
    // R6, R5 count down through zero
    step("R6 2->1", 0, 0, 1, 0, 0);
    step("R5 1->0 no irq", 0, 0, 1, 0, 0);
    chk("R5 no early irq", {63'd0, irq}, 64'd0);
    step("R5 0->-1 raise", 0, 0, 1, 0, 0);
    chk("R5 irq set", {63'd0, irq}, 64'd1);
    // R8 level: ack ignored, positive write clears
    step("R8 ack ignored", 0, 0, 0, 0, 1);
    chk("R8 irq held", {63'd0, irq}, 64'd1);
    step("R8 pos write clears", 1, 64'd5, 0, 0, 0);
    // R6 write 1 no irq
    step("R6 write 1", 1, 64'd1, 0, 0, 0);
    chk("R6 no irq", {63'd0, irq}, 64'd0);
    // R7 level negative write, R3 wrap
    step("R7 neg write", 1, MINV + 1, 0, 0, 0);
    step("R3 dec", 0, 0, 1, 0, 0);
    step("R3 wrap", 0, 0, 1, 0, 0);
    chk("R3 wrap value", rd_data, (MINV - 1));
    chk("R8 wrap keeps irq", {63'd0, irq}, 64'd1);
    step("R3 hold", 0, 0, 0, 0, 0);
    // R10 edge: positive write keeps, ack clears
    step("R10 pos write keeps", 1, 64'd3, 0, 1, 0);
    chk("R10 irq held", {63'd0, irq}, 64'd1);
    step("R10 ack clears", 0, 0, 0, 1, 1);
    chk("R10 irq cleared", {63'd0, irq}, 64'd0);
    // R9 edge writes
    step("R9 nonneg->neg", 1, 64'h9000_0000, 0, 1, 0);
    chk("R9 raise", {63'd0, irq}, 64'd1);
    step("R9 ack", 0, 0, 0, 1, 1);
    step("R9 neg->neg", 1, 64'hA000_0000, 0, 1, 0);
    chk("R9 no raise", {63'd0, irq}, 64'd0);
    // R7 level from negative
    step("R7 neg over neg", 1, 64'hA000_0001, 0, 0, 0);
    chk("R7 raise", {63'd0, irq}, 64'd1);
    // R10 set beats ack
    step("R10 prep", 1, 64'd0, 0, 0, 0);
    step("R10 uflow+ack", 0, 0, 1, 1, 1);
    chk("R10 set wins", {63'd0, irq}, 64'd1);

    // random mix
    md = 0;
    for (int i = 0; i < 6000; i++) begin
      if (i % 700 == 0) md = $urandom_range(0, 1);
      wr = ($urandom_range(0, 7) == 0);
      tk = ($urandom_range(0, 3) != 0);
      ak = ($urandom_range(0, 7) == 0);
      r  = $urandom_range(0, 3);
      case (r)
        0: d = {$urandom(), $urandom()};
        1: d = {$urandom(), 32'd0} | 64'($urandom_range(0, 3));
        2: d = MINV + 64'($urandom_range(0, 2));
        default: d = 64'($urandom_range(0, 6));
      endcase
      step("random R3 R5 R7 R9 R10", wr, d, tk, md, ak);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule